// File: doc/BRIEF.md
# Video Output Blanking and Timing-Word Stage

This block is a per-word processing stage for a 10-bit parallel digital video stream, placed just ahead of a serial encoder. An upstream timing extractor tells it where each line and field begins, where the four-word timing reference sequences (TRS) sit, whether the current word lies in horizontal blanking, and which field is being sent. Static control pins choose the television standard, the vertical blanking length, and which of the stage's functions are enabled. Data words that are only 8 bits wide are carried in the upper bits of the 10-bit bus.

The stage does four things. It can force every non-timing word to the blanking level that suits its position. It blanks the active part of the first lines of each field over a selectable count. It clamps active-picture words into the legal range. It rewrites every TRS from its own timing. It can also mirror the bit order of the output bus. Every control pin is captured in the same register as the data word it accompanies. A word therefore always leaves the stage after the same number of clocks, and it carries the settings that were present when it entered.

A small state machine names the role of each word. It has four states. ST_DATA marks a plain word. ST_Z1 and ST_Z2 mark the two zero words of a TRS, and ST_XYZ marks its final timing word. A TRS start pulse makes the current word the all-ones word and moves the machine to ST_Z1 from any state. Without that pulse the machine steps ST_Z1 -> ST_Z2, then ST_Z2 -> ST_XYZ, then ST_XYZ -> ST_DATA, and it stays in ST_DATA.

Top module: `sdi_blank_stage`

## Requirements
- R1: A word sampled at rising edge k, together with the control pins sampled at that edge, shows at `dout` right after edge k+7. That is eight register stages counting the input register, and the count is the same with every function enabled or disabled.
- R2: While `rst_n` is low, `dout` is 0x000.
- R3: With `blank_n` low, every word outside the four TRS positions is replaced by a blanking level. The level is 0x200 at even word positions and 0x040 at odd ones. Positions are counted from 0 at the word that carries `line_start`.
- R4: With `clip_en` high, the first three TRS words leave as 0x3FF, 0x000 and 0x000, whatever arrived. The TRS positions are the word that carries `trs_start` and the three words after it.
- R5: With `clip_en` high, the fourth TRS word is rebuilt from local timing. Bit 9 is 1, bit 8 is F (`field_id`), bit 7 is V, and bit 6 is H (`hblank` at that word). Bit 5 is V^H, bit 4 is F^H, bit 3 is F^V, bit 2 is F^V^H, and bits 1:0 are 0.
- R6: The line index is 0 on the line whose first word carries both `line_start` and `field_start`. It rises by one at each later `line_start`. V is 1 while the index is below N. N is 19 (`vb_short`=0) or 9 (`vb_short`=1) with `std_pal`=0, and 17 or 7 with `std_pal`=1.
- R7: With `clip_en` and `blank_n` high, a non-TRS word with `hblank` low on a line where V is 1 is replaced by the blanking level of R3.
- R8: With `clip_en` and `blank_n` high, a non-TRS word with `hblank` low on a line where V is 0 is clamped. Values below 0x004 become 0x004, values above 0x3FB become 0x3FB, and values in between pass unchanged.
- R9: With `clip_en` and `blank_n` high, a non-TRS word with `hblank` high is replaced by the R3 blanking level if it is 0x000-0x003 or 0x3FC-0x3FF. Any other value passes unchanged.
- R10: With `clip_en` low, the TRS words pass unchanged. If `blank_n` is also high, every word passes unchanged.
- R11: With `bit_rev` high, `dout[i]` carries bit 9-i of the processed word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 10 | Incoming video word |
| line_start | input | 1 | High on the first word of a line |
| field_start | input | 1 | High with `line_start` on the first line of a field |
| trs_start | input | 1 | High on the first word (all ones) of a TRS |
| hblank | input | 1 | High during the end-of-active TRS and horizontal blanking, low from the start-of-active TRS on |
| field_id | input | 1 | Field bit F |
| blank_n | input | 1 | Low forces non-TRS words to blanking levels |
| vb_short | input | 1 | Selects the short vertical blanking count |
| std_pal | input | 1 | 0: 525-line counts (19/9), 1: 625-line composite counts (17/7) |
| clip_en | input | 1 | Enables TRS rewrite, active clamping and blanking-region code cleanup |
| bit_rev | input | 1 | Mirrors the output bit order |
| dout | output | 10 | Processed word, eight clocks behind `din` |

## Verification
The bench sweeps all 32 combinations of the five control pins. For each combination it sends two fields of short lines, so that the last blanked line and the first open line are seen for every count. The active words in the sweep include the exact clamp edges 0x003/0x004 and 0x3FB/0x3FC. A clamp that is off by one would let a reserved code through or alter a legal value. The TRS inputs are deliberately corrupted, and the field bit alternates. A wrong protection bit or a stale V therefore shows up in the fourth TRS word. Because the settings change at field boundaries while data keeps flowing, any control that is not delayed together with its word corrupts the words that straddle each change.

// File: rtl/sdi_blank_pkg.sv
package sdi_blank_pkg;

    localparam int WORD_W = 10;

    typedef logic [WORD_W-1:0] vword_t;

    localparam vword_t LVL_CHROMA = 10'h200;
    localparam vword_t LVL_LUMA   = 10'h040;
    localparam vword_t CLIP_LO    = 10'h004;
    localparam vword_t CLIP_HI    = 10'h3FB;
    localparam vword_t TRS_ONES   = 10'h3FF;

    typedef enum logic [1:0] {
        ROLE_DATA,
        ROLE_ONES,
        ROLE_ZERO,
        ROLE_XYZ
    } word_role_e;

    typedef struct packed {
        vword_t word;
        logic   line_start;
        logic   field_start;
        logic   trs_start;
        logic   hblank;
        logic   field_id;
        logic   blank_n;
        logic   vb_short;
        logic   std_pal;
        logic   clip_en;
        logic   bit_rev;
    } in_word_t;

    typedef struct packed {
        vword_t word;
        logic   rev;
    } out_word_t;

    function automatic vword_t xyz_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

    function automatic logic is_reserved(input vword_t w);
        return (w <= 10'h003) || (w >= 10'h3FC);
    endfunction

    function automatic vword_t mirror(input vword_t w);
        vword_t r;
        for (int i = 0; i < WORD_W; i++) begin
            r[i] = w[WORD_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/sdi_trs_tracker.sv
module sdi_trs_tracker
    import sdi_blank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trs_start,
    output word_role_e role
);

    typedef enum logic [1:0] {ST_DATA, ST_Z1, ST_Z2, ST_XYZ} trs_state_e;

    trs_state_e state_q;
    trs_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DATA;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = ST_DATA;
        if (trs_start) begin
            state_d = ST_Z1;
        end else begin
            unique case (state_q)
                ST_Z1:   state_d = ST_Z2;
                ST_Z2:   state_d = ST_XYZ;
                ST_XYZ:  state_d = ST_DATA;
                ST_DATA: state_d = ST_DATA;
            endcase
        end
    end

    always_comb begin
        role = ROLE_DATA;
        if (trs_start) begin
            role = ROLE_ONES;
        end else begin
            unique case (state_q)
                ST_Z1, ST_Z2: role = ROLE_ZERO;
                ST_XYZ:       role = ROLE_XYZ;
                ST_DATA:      role = ROLE_DATA;
            endcase
        end
    end

    // R4
    z2_to_xyz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_Z2 && !trs_start) |=> (state_q == ST_XYZ));

    // R4
    start_to_z1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trs_start |=> (state_q == ST_Z1));

endmodule

// File: rtl/sdi_line_timer.sv
module sdi_line_timer #(
    parameter int LINE_W     = 11,
    parameter int NTSC_LONG  = 19,
    parameter int NTSC_SHORT = 9,
    parameter int PAL_LONG   = 17,
    parameter int PAL_SHORT  = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic field_start,
    input  logic vb_short,
    input  logic std_pal,
    output logic vblank,
    output logic chroma
);

    localparam logic [LINE_W-1:0] LINE_MAX = '1;
    localparam logic [LINE_W-1:0] N_NL = LINE_W'(NTSC_LONG);
    localparam logic [LINE_W-1:0] N_NS = LINE_W'(NTSC_SHORT);
    localparam logic [LINE_W-1:0] N_PL = LINE_W'(PAL_LONG);
    localparam logic [LINE_W-1:0] N_PS = LINE_W'(PAL_SHORT);

    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] line_cur;
    logic [LINE_W-1:0] vb_len;
    logic              odd_q;
    logic              odd_cur;

    always_comb begin
        line_cur = line_q;
        if (line_start) begin
            if (field_start) begin
                line_cur = '0;
            end else if (line_q != LINE_MAX) begin
                line_cur = line_q + 1'b1;
            end
        end
        odd_cur = line_start ? 1'b0 : ~odd_q;
        vb_len  = std_pal ? (vb_short ? N_PS : N_PL) : (vb_short ? N_NS : N_NL);
    end

    assign vblank = (line_cur < vb_len);
    assign chroma = ~odd_cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            odd_q  <= 1'b1;
        end else begin
            line_q <= line_cur;
            odd_q  <= odd_cur;
        end
    end

    // R6
    field_top_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && field_start) |-> vblank);

    // R3
    parity_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chroma |=> (line_start || !chroma));

endmodule

// File: rtl/sdi_word_shaper.sv
module sdi_word_shaper
    import sdi_blank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  vword_t     din,
    input  word_role_e role,
    input  logic       vblank,
    input  logic       chroma,
    input  logic       hblank,
    input  logic       field_id,
    input  logic       blank_n,
    input  logic       clip_en,
    input  logic       rev_in,
    output out_word_t  proc_q
);

    vword_t level;
    vword_t shaped;

    always_comb begin
        level  = chroma ? LVL_CHROMA : LVL_LUMA;
        shaped = din;
        if (role != ROLE_DATA) begin
            if (clip_en) begin
                unique case (role)
                    ROLE_ONES: shaped = TRS_ONES;
                    ROLE_ZERO: shaped = '0;
                    ROLE_XYZ:  shaped = xyz_word(field_id, vblank, hblank);
                    ROLE_DATA: shaped = din;
                endcase
            end
        end else if (!blank_n) begin
            shaped = level;
        end else if (clip_en) begin
            if (!hblank && vblank) begin
                shaped = level;
            end else if (!hblank) begin
                if (din < CLIP_LO) begin
                    shaped = CLIP_LO;
                end else if (din > CLIP_HI) begin
                    shaped = CLIP_HI;
                end
            end else if (is_reserved(din)) begin
                shaped = level;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            proc_q <= '0;
        end else begin
            proc_q <= '{word: shaped, rev: rev_in};
        end
    end

    // R8
    clamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (role == ROLE_DATA && blank_n && clip_en && !hblank)
        |=> (proc_q.word >= CLIP_LO && proc_q.word <= CLIP_HI));

    // R5
    xyz_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (role == ROLE_XYZ && clip_en)
        |=> (proc_q.word[9] && proc_q.word[1:0] == 2'b00
             && proc_q.word[5] == (proc_q.word[7] ^ proc_q.word[6])
             && proc_q.word[2] == (proc_q.word[8] ^ proc_q.word[7] ^ proc_q.word[6])));

    // R10
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clip_en && blank_n) |=> (proc_q.word == $past(din)));

endmodule

// File: rtl/sdi_delay_line.sv
module sdi_delay_line #(
    parameter int DEPTH = 6,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[i] <= '0;
                else        stage[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[i] <= '0;
                else        stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[DEPTH-1];

endmodule

// File: rtl/sdi_blank_stage.sv
module sdi_blank_stage
    import sdi_blank_pkg::*;
#(
    parameter int LATENCY    = 8,
    parameter int LINE_W     = 11,
    parameter int NTSC_LONG  = 19,
    parameter int NTSC_SHORT = 9,
    parameter int PAL_LONG   = 17,
    parameter int PAL_SHORT  = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [9:0]  din,
    input  logic        line_start,
    input  logic        field_start,
    input  logic        trs_start,
    input  logic        hblank,
    input  logic        field_id,
    input  logic        blank_n,
    input  logic        vb_short,
    input  logic        std_pal,
    input  logic        clip_en,
    input  logic        bit_rev,
    output logic [9:0]  dout
);

    localparam int DELAY  = LATENCY - 2;
    localparam int PIPE_W = $bits(out_word_t);

    in_word_t          in_q;
    word_role_e        role;
    logic              vblank;
    logic              chroma;
    out_word_t         proc_q;
    logic [PIPE_W-1:0] pipe_out;
    out_word_t         last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q <= '0;
        end else begin
            in_q <= '{word: din, line_start: line_start, field_start: field_start,
                      trs_start: trs_start, hblank: hblank, field_id: field_id,
                      blank_n: blank_n, vb_short: vb_short, std_pal: std_pal,
                      clip_en: clip_en, bit_rev: bit_rev};
        end
    end

    sdi_trs_tracker u_trs (
        .clk       (clk),
        .rst_n     (rst_n),
        .trs_start (in_q.trs_start),
        .role      (role)
    );

    sdi_line_timer #(
        .LINE_W     (LINE_W),
        .NTSC_LONG  (NTSC_LONG),
        .NTSC_SHORT (NTSC_SHORT),
        .PAL_LONG   (PAL_LONG),
        .PAL_SHORT  (PAL_SHORT)
    ) u_lines (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_start  (in_q.line_start),
        .field_start (in_q.field_start),
        .vb_short    (in_q.vb_short),
        .std_pal     (in_q.std_pal),
        .vblank      (vblank),
        .chroma      (chroma)
    );

    sdi_word_shaper u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (in_q.word),
        .role     (role),
        .vblank   (vblank),
        .chroma   (chroma),
        .hblank   (in_q.hblank),
        .field_id (in_q.field_id),
        .blank_n  (in_q.blank_n),
        .clip_en  (in_q.clip_en),
        .rev_in   (in_q.bit_rev),
        .proc_q   (proc_q)
    );

    sdi_delay_line #(
        .DEPTH (DELAY),
        .W     (PIPE_W)
    ) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (proc_q),
        .q     (pipe_out)
    );

    assign last = out_word_t'(pipe_out);
    assign dout = last.rev ? mirror(last.word) : last.word;

    // R2
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (dout == '0));

endmodule

// File: tb/sdi_blank_stage_bench.sv
module sdi_blank_stage_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] din = '0;
    logic       line_start = 0, field_start = 0, trs_start = 0, hblank = 0, field_id = 0;
    logic       blank_n = 1, vb_short = 0, std_pal = 0, clip_en = 0, bit_rev = 0;
    logic [9:0] dout;

    sdi_blank_stage u_sdi_blank_stage (
        .clk(clk), .rst_n(rst_n), .din(din), .line_start(line_start),
        .field_start(field_start), .trs_start(trs_start), .hblank(hblank),
        .field_id(field_id), .blank_n(blank_n), .vb_short(vb_short),
        .std_pal(std_pal), .clip_en(clip_en), .bit_rev(bit_rev), .dout(dout)
    );

    always #4 clk = ~clk;

    int         n_checks = 0;
    int         n_fail   = 0;
    int         wcount   = 0;
    bit         done     = 0;
    logic [9:0] exp_ring [16];
    string      tag_ring [16];
    bit         val_ring [16];

    function automatic logic [9:0] rev10(input logic [9:0] x);
        logic [9:0] r;
        for (int i = 0; i < 10; i++) r[i] = x[9-i];
        return r;
    endfunction

    function automatic logic [9:0] edge_code(input int k);
        case (k & 7)
            0: return 10'h000;
            1: return 10'h003;
            2: return 10'h004;
            3: return 10'h3FB;
            4: return 10'h3FC;
            5: return 10'h3FF;
            6: return 10'h200;
            default: return 10'h040;
        endcase
    endfunction

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: dout=%h expected=%h", tag, act, exp);
        end
    endtask

    // R1: the word driven now is compared eight positions later
    task automatic step(input logic [9:0] w, input bit sol, input bit sof, input bit trs,
                        input bit h, input bit f, input bit bn, input bit vs, input bit sp,
                        input bit cl, input bit rv, input bit keep,
                        input logic [9:0] ex, input string tg);
        @(negedge clk);
        if (wcount >= 8 && val_ring[(wcount - 8) & 15])
            check(tag_ring[(wcount - 8) & 15], dout, exp_ring[(wcount - 8) & 15]);
        din = w; line_start = sol; field_start = sof; trs_start = trs; hblank = h;
        field_id = f; blank_n = bn; vb_short = vs; std_pal = sp; clip_en = cl; bit_rev = rv;
        val_ring[wcount & 15] = keep;
        exp_ring[wcount & 15] = ex;
        tag_ring[wcount & 15] = {tg, "/R1"};
        wcount++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit sp, vs, cl, bn, rv, sol, sof, trs, h, f, vv, trs_pos;
        int vblen, tw;
        logic [9:0] w, ex, lvl;
        string tg;

        repeat (3) @(negedge clk);
        // R2: output held at zero during reset
        check("R2", dout, 10'h000);
        din = 10'h3FF;
        @(negedge clk);
        check("R2", dout, 10'h000);
        rst_n = 1'b1;

        for (int cfg = 0; cfg < 32; cfg++) begin
            sp = cfg[0]; vs = cfg[1]; cl = cfg[2]; bn = ~cfg[3]; rv = cfg[4];
            vblen = sp ? (vs ? 7 : 17) : (vs ? 9 : 19);
            for (int fld = 0; fld < 2; fld++) begin
                for (int ln = 0; ln < 22; ln++) begin
                    for (int wi = 0; wi < 20; wi++) begin
                        sol = (wi == 0);
                        sof = sol && (ln == 0);
                        trs = (wi == 0) || (wi == 8);
                        h   = (wi < 8);
                        f   = fld[0];
                        vv  = (ln < vblen);
                        trs_pos = (wi < 4) || (wi >= 8 && wi < 12);
                        tw  = wi & 3;
                        lvl = (wi % 2 == 0) ? 10'h200 : 10'h040;
                        if (trs_pos) begin
                            case (tw)
                                0: w = (ln % 3 == 0) ? 10'h3FF : 10'h3FE;
                                1: w = ln[0] ? 10'h000 : 10'h001;
                                2: w = (ln % 5 == 0) ? 10'h004 : 10'h000;
                                default: w = 10'((ln * 29 + cfg * 7) & 10'h3FF);
                            endcase
                        end else if (h) begin
                            case (wi - 4)
                                0: w = edge_code(((ln + cfg) % 2 == 0) ? 0 : 5) ^ ((ln % 4 == 1) ? 10'h002 : 10'h000);
                                1: w = 10'((ln * 53 + cfg) & 10'h3FF);
                                2: w = ln[0] ? 10'h3FD : 10'h100;
                                default: w = (ln % 3 == 1) ? 10'h001 : 10'h2AA;
                            endcase
                        end else begin
                            w = (ln[0] == 1'b0) ? edge_code(wi - 12)
                                                : 10'((ln * 97 + (wi - 12) * 41 + cfg * 13) & 10'h3FF);
                        end

                        if (trs_pos) begin
                            if (cl) begin
                                case (tw)
                                    0: ex = 10'h3FF;
                                    1, 2: ex = 10'h000;
                                    default: ex = {1'b1, f, vv, h, vv ^ h, f ^ h, f ^ vv, f ^ vv ^ h, 2'b00};
                                endcase
                                tg = (tw == 3) ? "R5" : "R4";
                            end else begin
                                ex = w; tg = "R10";
                            end
                        end else if (!bn) begin
                            ex = lvl; tg = "R3";
                        end else if (cl) begin
                            if (!h && vv) begin
                                ex = lvl;
                                tg = (ln == vblen - 1) ? "R6" : "R7";
                            end else if (!h) begin
                                ex = (w < 10'h004) ? 10'h004 : ((w > 10'h3FB) ? 10'h3FB : w);
                                tg = (ln == vblen) ? "R6" : "R8";
                            end else begin
                                ex = (w <= 10'h003 || w >= 10'h3FC) ? lvl : w;
                                tg = "R9";
                            end
                        end else begin
                            ex = w; tg = "R10";
                        end
                        if (rv) begin
                            ex = rev10(ex);
                            tg = {"R11 ", tg};
                        end
                        step(w, sol, sof, trs, h, f, bn, vs, sp, cl, rv, 1'b1, ex, tg);
                    end
                end
            end
        end
        for (int k = 0; k < 8; k++) begin
            step(10'h040, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000, "flush");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule